// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames from a byte-wide stream and stores each one in memory through a ring of two-word buffer descriptors. The ring lives at a word address given on an input. For every frame, the block fetches the current descriptor and checks whether software still holds it. If the block owns it, the block writes the payload into the buffer, then the status word, and last the ownership bit. Software then reads the descriptor and hands it back by clearing that bit.

The memory side is a single word-addressed port with one request per cycle. It needs no grant, and read data returns one cycle after the request. The byte stream has a ready signal, so the source waits while a descriptor is being fetched or written back. The ownership and wrap markers share the address word with the buffer pointer. The block masks them off to form the buffer address. It sets ownership by writing back the word it read, with bit 0 added.

Top module: `rxring_wb`

## Requirements
- R1: After reset, `in_ready` and `mem_req` are low, and the first frame uses the descriptor at `ring_base`.
- R2: Stored payload byte k goes into lane k%4 of word k/4, starting at the word address held in address-word bits [31:2]. Lane 0 is bits [7:0]. Unused lanes of a final partial word are zero.
- R3: After the payload, the status word is written at descriptor address + 1. It holds bit 15 (end of frame) = 1, bit 14 (start of frame) = 1, bits [13:0] = stored length, and all other bits 0.
- R4: In the cycle right after the status write, the address word at the descriptor address is written back. It equals the word that was fetched with bit 0 (used) set.
- R5: Each completed frame advances the descriptor by two words. After a descriptor whose address-word bit 1 (wrap) is set, the next one is at `ring_base`.
- R6: If the fetched descriptor already has bit 0 set, the whole frame is accepted and discarded. No memory write occurs, `nobuf` pulses for one cycle, and the same descriptor is tried for the next frame.
- R7: While idle with `rx_en` low, `in_ready` and `mem_req` stay low. Clearing `rx_en` during a frame does not stop that frame from being stored completely.
- R8: Bytes past `BUF_BYTES` are consumed but not written, and the length field saturates at `BUF_BYTES`.
- R9: `frame_done` pulses for one cycle, in the cycle after the ownership write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled between frames |
| ring_base | input | ADDR_W | Word address of the first descriptor |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| frame_done | output | 1 | One-cycle pulse when a descriptor is handed to software |
| nobuf | output | 1 | One-cycle pulse when a frame is dropped for lack of a descriptor |

## Verification
- **Payload writes (R2):** each payload word is written in the same cycle that its fourth byte, or the frame's last byte, is accepted.
- **Descriptor write-back (R3, R4):** the status write follows in the next cycle, and the ownership write in the cycle after that.
- **Pulses (R6, R9):** `frame_done` rises one cycle after the ownership write. `nobuf` rises one cycle after the fetch that found the descriptor busy.
- **How the bench keeps to this timing:** it queues every expected write in order and compares each write at the falling edge of the cycle in which it is issued. It counts both pulses and compares the counts after a settle gap of several cycles that follows every frame.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int unsigned LEN_W = 14;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FILL, S_DRAIN, S_STAT, S_OWN
  } rx_state_t;

  function automatic logic [29:0] buf_word(input logic [31:0] aw);
    return aw[31:2];
  endfunction

  function automatic logic [31:0] status_word(input logic [LEN_W-1:0] len);
    return {16'h0000, 1'b1, 1'b1, len};
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] acc,
                                             input logic [7:0] b,
                                             input logic [1:0] lane);
    logic [31:0] r;
    r = (lane == 2'd0) ? 32'h0 : acc;
    r[8*lane +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/rxring_pack.sv
module rxring_pack
  import rxring_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 1536,
  localparam int unsigned IDX_W = LEN_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       byte_in,
  input  logic             last_in,
  output logic             wr,
  output logic [31:0]      wdata,
  output logic [IDX_W-1:0] word_idx,
  output logic [LEN_W-1:0] stored_len
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(BUF_BYTES);

  logic [LEN_W-1:0] cnt;
  logic [31:0]      acc;
  logic             room;
  logic [1:0]       lane;

  assign room       = cnt < LIMIT;
  assign lane       = cnt[1:0];
  assign wdata      = lane_merge(acc, byte_in, lane);
  assign wr         = take && room && (lane == 2'd3 || last_in);
  assign word_idx   = cnt[LEN_W-1:2];
  assign stored_len = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (clr) begin
      cnt <= '0;
      acc <= '0;
    end else if (take && room) begin
      cnt <= cnt + 1'b1;
      acc <= (lane == 2'd3) ? 32'h0 : wdata;
    end
  end
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int unsigned ADDR_W = 30,
  localparam int unsigned IDX_W = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              take,
  output logic              clr,
  input  logic              pack_wr,
  input  logic [31:0]       pack_wdata,
  input  logic [IDX_W-1:0]  pack_idx,
  input  logic [LEN_W-1:0]  stored_len,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              frame_done,
  output logic              nobuf,
  output logic              ev_pay_wr,
  output logic              ev_stat_wr,
  output logic              ev_own_wr,
  output logic              in_drop
);
  rx_state_t         st, nxt;
  logic [ADDR_W-1:0] off;
  logic [31:0]       desc_q;
  logic [ADDR_W-1:0] desc_addr, buf_base;

  assign desc_addr  = ring_base + off;
  assign buf_base   = ADDR_W'(buf_word(desc_q));
  assign ev_pay_wr  = (st == S_FILL) && pack_wr;
  assign ev_stat_wr = (st == S_STAT);
  assign ev_own_wr  = (st == S_OWN);
  assign in_drop    = (st == S_DRAIN);

  always_comb begin
    nxt       = st;
    in_ready  = 1'b0;
    take      = 1'b0;
    clr       = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = 32'h0;
    case (st)
      S_IDLE: if (rx_en && in_valid) begin
        mem_req = 1'b1;
        clr     = 1'b1;
        nxt     = S_FETCH;
      end
      S_FETCH: nxt = mem_rdata[0] ? S_DRAIN : S_FILL;
      S_FILL: begin
        in_ready = 1'b1;
        take     = in_valid;
        if (pack_wr) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = buf_base + ADDR_W'(pack_idx);
          mem_wdata = pack_wdata;
        end
        if (in_valid && in_last) nxt = S_STAT;
      end
      S_DRAIN: begin
        in_ready = 1'b1;
        if (in_valid && in_last) nxt = S_IDLE;
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + ADDR_W'(1);
        mem_wdata = status_word(stored_len);
        nxt       = S_OWN;
      end
      S_OWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = desc_q | 32'h1;
        nxt       = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      off        <= '0;
      desc_q     <= '0;
      frame_done <= 1'b0;
      nobuf      <= 1'b0;
    end else begin
      st         <= nxt;
      frame_done <= (st == S_OWN);
      nobuf      <= (st == S_FETCH) && mem_rdata[0];
      if (st == S_FETCH) desc_q <= mem_rdata;
      if (st == S_OWN) off <= desc_q[1] ? '0 : off + ADDR_W'(2);
    end
  end
endmodule

// File: rtl/rxring_wb.sv
module rxring_wb
  import rxring_pkg::*;
#(
  parameter int unsigned ADDR_W    = 30,
  parameter int unsigned BUF_BYTES = 1536,
  localparam int unsigned IDX_W = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              frame_done,
  output logic              nobuf
);
  logic             take, clr, pack_wr;
  logic [31:0]      pack_wdata;
  logic [IDX_W-1:0] pack_idx;
  logic [LEN_W-1:0] stored_len;
  logic             ev_pay_wr, ev_stat_wr, ev_own_wr, in_drop;

  rxring_pack #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take),
    .byte_in(in_data), .last_in(in_last), .wr(pack_wr),
    .wdata(pack_wdata), .word_idx(pack_idx), .stored_len(stored_len)
  );

  rxring_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .take(take), .clr(clr), .pack_wr(pack_wr), .pack_wdata(pack_wdata),
    .pack_idx(pack_idx), .stored_len(stored_len), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .frame_done(frame_done), .nobuf(nobuf),
    .ev_pay_wr(ev_pay_wr), .ev_stat_wr(ev_stat_wr), .ev_own_wr(ev_own_wr),
    .in_drop(in_drop)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int unsigned ADDR_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ev_pay_wr,
  input logic              ev_stat_wr,
  input logic              ev_own_wr,
  input logic              in_drop,
  input logic              frame_done,
  input logic              nobuf
);
  assert_own_after_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_wr |-> $past(ev_stat_wr));

  assert_status_then_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |=> (ev_own_wr && (mem_addr + ADDR_W'(1) == $past(mem_addr))));

  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_drop |-> !mem_req);

  assert_nobuf_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nobuf |=> !nobuf);

  assert_done_after_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(ev_own_wr));

  assert_single_write_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_pay_wr, ev_stat_wr, ev_own_wr}));
endmodule

bind rxring_wb rxring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .ev_pay_wr(ev_pay_wr), .ev_stat_wr(ev_stat_wr), .ev_own_wr(ev_own_wr),
  .in_drop(in_drop), .frame_done(frame_done), .nobuf(nobuf)
);

// File: tb/sim_rxring_wb.sv
`timescale 1ns/1ps
module sim_rxring_wb;
  localparam int AW = 30;
  localparam int BUFB = 1536;
  localparam int ND = 4;
  localparam logic [29:0] BASE = 30'h100;

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h0;
  logic in_ready, mem_req, mem_we, frame_done, nobuf;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  rxring_wb #(.ADDR_W(AW), .BUF_BYTES(BUFB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(BASE),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .frame_done(frame_done), .nobuf(nobuf)
  );

  logic [31:0] mem [int unsigned];
  logic [63:0] exp_q [$];
  string       tag_q [$];
  int tests = 0, fails = 0;
  int done_cnt = 0, nobuf_cnt = 0, exp_done = 0, exp_nobuf = 0;
  int ring_i = 0;
  bit sw_used [ND];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] bufw(input int i);
    return 30'h1000 + 30'(i) * 30'h200;
  endfunction

  function automatic logic [31:0] desc_word(input int i);
    return {bufw(i), (i == ND - 1) ? 1'b1 : 1'b0, 1'b0};
  endfunction

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed + k * 7) & 8'hFF);
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[32'(mem_addr)] = mem_wdata;
      else mem_rdata <= mem.exists(32'(mem_addr)) ? mem[32'(mem_addr)] : 32'h0;
    end
  end

  // monitor: compare every write in order
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) done_cnt++;
      if (nobuf) nobuf_cnt++;
      if (mem_req && mem_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected write", {2'b0, mem_addr, mem_wdata}, 64'h0);
        else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({2'b0, mem_addr, mem_wdata} == e, t, {2'b0, mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic push(input logic [29:0] a, input logic [31:0] d, input string t);
    exp_q.push_back({2'b0, a, d});
    tag_q.push_back(t);
  endtask

  task automatic send(input int len, input int seed, input int dis_at, input string t);
    int s;
    s = (len > BUFB) ? BUFB : len;
    if (sw_used[ring_i]) exp_nobuf++;
    else begin
      for (int w = 0; w < (s + 3) / 4; w++) begin
        logic [31:0] d;
        d = 32'h0;
        for (int b = 0; b < 4; b++)
          if (4 * w + b < s) d[8*b +: 8] = pat(seed, 4 * w + b);
        push(bufw(ring_i) + 30'(w), d, {t, " R2 payload"});
      end
      push(BASE + 30'(2 * ring_i) + 30'd1, 32'h0000C000 | 32'(s), {t, " R3 R8 status"});
      push(BASE + 30'(2 * ring_i), desc_word(ring_i) | 32'h1, {t, " R4 R5 ownership"});
      sw_used[ring_i] = 1'b1;
      ring_i = (ring_i == ND - 1) ? 0 : ring_i + 1;
      exp_done++;
    end
    for (int k = 0; k < len; k++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_data  = pat(seed, k);
      in_last  = (k == len - 1);
      if (k == dis_at) rx_en = 1'b0;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    rx_en = 1'b1;
    @(negedge clk);
    chk(done_cnt == exp_done, {t, " R9 frame_done count"}, 64'(done_cnt), 64'(exp_done));
    chk(nobuf_cnt == exp_nobuf, {t, " R6 nobuf count"}, 64'(nobuf_cnt), 64'(exp_nobuf));
  endtask

  task automatic give_back(input int i);
    mem[32'(BASE) + 32'(2 * i)] = desc_word(i);
    sw_used[i] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < ND; i++) give_back(i);
    repeat (4) @(negedge clk);
    chk(!in_ready && !mem_req, "R1 reset outputs", {in_ready, mem_req}, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    @(negedge clk);
    chk(!in_ready && !mem_req, "R1 idle outputs", {in_ready, mem_req}, 0);
    send(1, 3, -1, "R1 first");
    send(8, 17, -1, "len8");
    send(7, 40, -1, "len7");
    send(64, 90, -1, "wrapdesc");
    send(5, 11, -1, "busy R6");
    for (int i = 0; i < ND; i++) give_back(i);
    send(13, 55, -1, "afterwrap R5");
    // disabled while idle
    @(posedge clk); #1;
    rx_en = 1'b0;
    in_valid = 1'b1;
    begin
      bit seen;
      seen = 1'b0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (in_ready || mem_req) seen = 1'b1;
      end
      chk(!seen, "R7 disabled idle quiet", 64'(seen), 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    rx_en = 1'b1;
    send(20, 77, 5, "R7 disable midframe");
    send(1540, 9, -1, "R8 oversize");
    chk(exp_q.size() == 0, "R2 all writes seen", 64'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule